// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers a configurable number of 32-bit words of level-sensitive interrupt inputs and merges them into one active-high, level-sensitive request toward a parent controller. Software reaches it through a single-cycle 32-bit register port with a byte address, a write strobe, write data and combinational read data. Through this port software turns the block on, lets each source through or blocks it, raises a source by itself, reads the filtered pending bits for each word, and reads a one-bit-per-word summary.

Sources are numbered linearly across the flat input vector. The register map grows with the word count: the mask, software-set and status banks sit back to back after the control word, followed by a master-disable word and the summary word. There is no acknowledge register. A pending bit goes away only when its input drops, when its software-set bit is cleared, or when it is masked.

The parent request comes from a three-state machine. `ST_OFF` holds while the control enable bit is clear or any master-disable bit is set. `ST_QUIET` holds while the block is allowed to fire and nothing is pending. `ST_FIRING` holds while it is allowed to fire and at least one status bit is set. From any state, the transition *gate* goes to `ST_OFF`, *arm* goes to `ST_QUIET`, and *fire* goes to `ST_FIRING`. Each clock edge picks one of these from the current conditions, so the request follows its inputs one cycle later.

Top module: `irqagg_top`

## Requirements
- R1: After reset every register reads zero and `parent_irq_o` is low, so the block starts disabled with every source masked.
- R2: A mask word at byte address 4+4n reads back exactly the last value written to it.
- R3: The status word at byte address 4+4n+8N reads (input word n OR set word n) AND mask word n. A mask bit of 1 passes its source and a mask bit of 0 blocks it.
- R4: A 1 written to a bit of the set word at byte address 4+4n+4N makes that source pending, as long as the source is unmasked, until a 0 is written back to that bit.
- R5: The summary word at byte address 8+12N has bit n set exactly when status word n is nonzero. All its upper bits read zero.
- R6: With bit 0 of the control word (address 0) set and the master-disable word zero, `parent_irq_o` is high one cycle after any status bit is set. It goes low one cycle after none is set.
- R7: While bit 0 of the control word is clear, `parent_irq_o` is low from the next cycle on. The status reads are not affected.
- R8: While any bit of the master-disable word at byte address 4+12N is set, `parent_irq_o` is low from the next cycle on. The status and summary reads are unchanged.
- R9: Reads from addresses that are not mapped, including addresses that are not word-aligned, return zero. Writes to the status and summary addresses change no register.
- R10: Input bit 32*n+j of `src_i` is source j of word n, and it appears as bit j of status word n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32*NWORDS | Level-sensitive interrupt sources, linear numbering |
| reg_addr_i | input | AW | Register byte address |
| reg_we_i | input | 1 | Write strobe, takes effect at the clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| parent_irq_o | output | 1 | Active-high level request to the parent controller |

## Verification
On every cycle, the embedded assertions check that the parent request follows the gating rules of R6, R7 and R8 one cycle later. They also check that no status bit is set outside its mask, that the summary agrees with the status words, and that a mask write reads back. Only the bench scenarios can show the full register map at work. That covers the decode of every bank address, masking of mixed patterns across both words, how long a software-set bit holds, that writes to status addresses are ignored, and that unmapped or misaligned reads return zero.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int SRC_PER_WORD = 32;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_QUIET  = 2'd1,
        ST_FIRING = 2'd2
    } agg_state_e;
endpackage

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int NWORDS = 2,
    parameter int AW     = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [AW-1:0]                    addr_i,
    input  logic                             we_i,
    input  logic [31:0]                      wdata_i,
    input  logic [NWORDS*SRC_PER_WORD-1:0]   status_i,
    input  logic [NWORDS-1:0]                summary_i,
    output logic [31:0]                      rdata_o,
    output logic                             en_o,
    output logic                             gate_o,
    output logic [NWORDS*SRC_PER_WORD-1:0]   mask_o,
    output logic [NWORDS*SRC_PER_WORD-1:0]   set_o
);
    localparam int CTRL_ADDR  = 0;
    localparam int MASK_BASE  = 4;
    localparam int SET_BASE   = 4 + 4 * NWORDS;
    localparam int STAT_BASE  = 4 + 8 * NWORDS;
    localparam int MDIS_ADDR  = 4 + 12 * NWORDS;
    localparam int MSUM_ADDR  = MDIS_ADDR + 4;

    logic        en_q;
    logic [31:0] mdis_q;
    logic [31:0] mask_q [NWORDS];
    logic [31:0] set_q  [NWORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mdis_q <= '0;
        end else if (we_i) begin
            if (addr_i == AW'(CTRL_ADDR)) en_q   <= wdata_i[0];
            if (addr_i == AW'(MDIS_ADDR)) mdis_q <= wdata_i;
        end
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[w] <= '0;
                set_q[w]  <= '0;
            end else if (we_i) begin
                if (addr_i == AW'(MASK_BASE + 4 * w)) mask_q[w] <= wdata_i;
                if (addr_i == AW'(SET_BASE + 4 * w))  set_q[w]  <= wdata_i;
            end
        end
        assign mask_o[w*SRC_PER_WORD +: SRC_PER_WORD] = mask_q[w];
        assign set_o[w*SRC_PER_WORD +: SRC_PER_WORD]  = set_q[w];

        // R2: a mask write is visible in the register on the next cycle
        a_r2_mask_readback: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && addr_i == AW'(MASK_BASE + 4 * w)) |=> (mask_q[w] == $past(wdata_i)));
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(CTRL_ADDR)) rdata_o = {31'b0, en_q};
        if (addr_i == AW'(MDIS_ADDR)) rdata_o = mdis_q;
        if (addr_i == AW'(MSUM_ADDR)) rdata_o = {{(32-NWORDS){1'b0}}, summary_i};
        for (int w = 0; w < NWORDS; w++) begin
            if (addr_i == AW'(MASK_BASE + 4 * w)) rdata_o = mask_q[w];
            if (addr_i == AW'(SET_BASE + 4 * w))  rdata_o = set_q[w];
            if (addr_i == AW'(STAT_BASE + 4 * w))
                rdata_o = status_i[w*SRC_PER_WORD +: SRC_PER_WORD];
        end
    end

    assign en_o   = en_q;
    assign gate_o = |mdis_q;
endmodule

// File: rtl/irqagg_pending.sv
module irqagg_pending
    import irqagg_pkg::*;
#(
    parameter int NWORDS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NWORDS*SRC_PER_WORD-1:0] src_i,
    input  logic [NWORDS*SRC_PER_WORD-1:0] mask_i,
    input  logic [NWORDS*SRC_PER_WORD-1:0] set_i,
    output logic [NWORDS*SRC_PER_WORD-1:0] status_o,
    output logic [NWORDS-1:0]              summary_o,
    output logic                           any_o
);
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam int LO = w * SRC_PER_WORD;
        assign status_o[LO +: SRC_PER_WORD] =
            (src_i[LO +: SRC_PER_WORD] | set_i[LO +: SRC_PER_WORD]) & mask_i[LO +: SRC_PER_WORD];
        assign summary_o[w] = |status_o[LO +: SRC_PER_WORD];
    end

    assign any_o = |summary_o;

    // R3: no pending bit may appear outside its mask
    a_r3_status_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & ~mask_i) == '0));

    // R5: summary is empty exactly when all status words are empty
    a_r5_summary_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(summary_o) == 0) == (status_o == '0)));
endmodule

// File: rtl/irqagg_fsm.sv
module irqagg_fsm
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic gate_i,
    input  logic any_i,
    output logic irq_o
);
    agg_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_OFF, ST_QUIET, ST_FIRING: begin
                if (!en_i || gate_i) state_d = ST_OFF;     // gate
                else if (any_i)      state_d = ST_FIRING;  // fire
                else                 state_d = ST_QUIET;   // arm
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_FIRING);
    end

    // R7: disabled channel silences the request next cycle
    a_r7_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !irq_o);
    // R8: master disable silences the request next cycle
    a_r8_off_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
        gate_i |=> !irq_o);
    // R6: pending and allowed raises the request next cycle
    a_r6_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !gate_i && any_i) |=> irq_o);
    // R6: nothing pending drops the request next cycle
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !any_i |=> !irq_o);
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int NWORDS = 2,
    parameter int AW     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NWORDS*SRC_PER_WORD-1:0] src_i,
    input  logic [AW-1:0]                  reg_addr_i,
    input  logic                           reg_we_i,
    input  logic [31:0]                    reg_wdata_i,
    output logic [31:0]                    reg_rdata_o,
    output logic                           parent_irq_o
);
    localparam int NSRC = NWORDS * SRC_PER_WORD;

    logic [NSRC-1:0]   mask_w, set_w, status_w;
    logic [NWORDS-1:0] summary_w;
    logic              en_w, gate_w, any_w;

    irqagg_regs #(.NWORDS(NWORDS), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (reg_addr_i),
        .we_i      (reg_we_i),
        .wdata_i   (reg_wdata_i),
        .status_i  (status_w),
        .summary_i (summary_w),
        .rdata_o   (reg_rdata_o),
        .en_o      (en_w),
        .gate_o    (gate_w),
        .mask_o    (mask_w),
        .set_o     (set_w)
    );

    irqagg_pending #(.NWORDS(NWORDS)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .mask_i    (mask_w),
        .set_i     (set_w),
        .status_o  (status_w),
        .summary_o (summary_w),
        .any_o     (any_w)
    );

    irqagg_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_w),
        .gate_i (gate_w),
        .any_i  (any_w),
        .irq_o  (parent_irq_o)
    );
endmodule

// File: tb/sim_irqagg_top.sv
`timescale 1ns/1ps
module sim_irqagg_top;
    localparam int N  = 2;
    localparam int AW = 8;
    localparam logic [AW-1:0] A_CTRL = 8'h00;
    localparam logic [AW-1:0] A_M0   = 8'h04;
    localparam logic [AW-1:0] A_M1   = 8'h08;
    localparam logic [AW-1:0] A_S0   = AW'(4 + 4 * N);
    localparam logic [AW-1:0] A_S1   = AW'(8 + 4 * N);
    localparam logic [AW-1:0] A_T0   = AW'(4 + 8 * N);
    localparam logic [AW-1:0] A_T1   = AW'(8 + 8 * N);
    localparam logic [AW-1:0] A_MDIS = AW'(4 + 12 * N);
    localparam logic [AW-1:0] A_MSUM = AW'(8 + 12 * N);

    // {src0, src1, mask0, mask1, set0, set1}
    localparam int NV = 6;
    localparam logic [191:0] VEC [NV] = '{
        {32'h0000_0001, 32'h0,          32'hFFFF_FFFF, 32'h0,          32'h0,          32'h0},
        {32'hFFFF_0000, 32'hA5A5_A5A5, 32'h00FF_00FF, 32'h0F0F_0F0F, 32'h0,          32'h0},
        {32'h0,          32'h0,          32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,          32'h8000_0000},
        {32'h0000_1234, 32'h0,          32'h0,          32'h0,          32'h0000_FFFF, 32'h0},
        {32'h0,          32'h0000_0020, 32'h0,          32'h0000_0020, 32'h0,          32'h0},
        {32'hDEAD_BEEF, 32'h0,          32'h0000_FFFF, 32'h0,          32'h0001_0000, 32'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N*32-1:0] src = '0;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;
    int            errors = 0;
    int            checks = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    irqagg_top #(.NWORDS(N), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr_i(addr),
        .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .parent_irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #1 we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_M0, v);   chk("R1 mask0", v, 32'h0);
        rd(A_S1, v);   chk("R1 set1", v, 32'h0);
        rd(A_MDIS, v); chk("R1 mdis", v, 32'h0);
        src = '1;
        settle();
        rd(A_T0, v);   chk("R1 masked status", v, 32'h0);
        chk("R1 irq after inputs", {31'b0, irq}, 32'h0);
        src = '0;

        wr(A_CTRL, 32'h1);
        for (int i = 0; i < NV; i++) begin
            logic [31:0] s0, s1, m0, m1, t0, t1, e0, e1;
            s0 = VEC[i][191:160]; s1 = VEC[i][159:128];
            m0 = VEC[i][127:96];  m1 = VEC[i][95:64];
            t0 = VEC[i][63:32];   t1 = VEC[i][31:0];
            wr(A_M0, m0); wr(A_M1, m1); wr(A_S0, t0); wr(A_S1, t1);
            src = {s1, s0};
            settle();
            e0 = (s0 | t0) & m0;
            e1 = (s1 | t1) & m1;
            rd(A_M0, v); chk("R2 mask0 readback", v, m0);
            rd(A_M1, v); chk("R2 mask1 readback", v, m1);
            rd(A_T0, v); chk("R3 status0", v, e0);
            rd(A_T1, v); chk("R3 status1 / R10 numbering", v, e1);
            rd(A_MSUM, v); chk("R5 summary", v, {30'b0, |e1, |e0});
            chk("R6 irq", {31'b0, irq}, {31'b0, |{e1, e0}});
        end

        // R4: software set holds, then releases
        src = '0;
        wr(A_M0, 32'hFFFF_FFFF); wr(A_M1, 32'h0); wr(A_S1, 32'h0);
        wr(A_S0, 32'h0000_0002);
        settle();
        rd(A_T0, v); chk("R4 set holds", v, 32'h2);
        chk("R4 irq while set", {31'b0, irq}, 32'h1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R4 irq still held", {31'b0, irq}, 32'h1);
        wr(A_S0, 32'h0);
        settle();
        chk("R4/R6 irq after clear", {31'b0, irq}, 32'h0);

        // R10: source 32*1+5
        wr(A_M1, 32'hFFFF_FFFF);
        src = '0; src[37] = 1'b1;
        settle();
        rd(A_T1, v); chk("R10 word1 bit5", v, 32'h20);
        rd(A_T0, v); chk("R10 word0 clear", v, 32'h0);
        rd(A_MSUM, v); chk("R10 summary", v, 32'h2);

        // R7: disable channel
        wr(A_CTRL, 32'h0);
        settle();
        chk("R7 irq off", {31'b0, irq}, 32'h0);
        rd(A_T1, v); chk("R7 status kept", v, 32'h20);
        wr(A_CTRL, 32'h1);
        settle();
        chk("R6 irq re-enabled", {31'b0, irq}, 32'h1);

        // R8: master disable
        wr(A_MDIS, 32'h8000_0000);
        settle();
        chk("R8 irq gated", {31'b0, irq}, 32'h0);
        rd(A_T1, v);   chk("R8 status kept", v, 32'h20);
        rd(A_MSUM, v); chk("R8 summary kept", v, 32'h2);
        wr(A_MDIS, 32'h0);
        settle();
        chk("R8 irq released", {31'b0, irq}, 32'h1);

        // R9: read-only and unmapped
        wr(A_T1, 32'h0);
        wr(A_MSUM, 32'hFFFF_FFFF);
        rd(A_T1, v); chk("R9 status write ignored", v, 32'h20);
        rd(A_M1, v); chk("R9 mask untouched", v, 32'hFFFF_FFFF);
        rd(A_S1, v); chk("R9 set untouched", v, 32'h0);
        rd(A_MDIS, v); chk("R9 mdis untouched", v, 32'h0);
        rd(8'hF0, v); chk("R9 unmapped read", v, 32'h0);
        rd(8'h09, v); chk("R9 misaligned read", v, 32'h0);
        settle();
        chk("R9 irq unaffected", {31'b0, irq}, 32'h1);

        // R6: input drops, request drops
        src = '0;
        settle();
        chk("R6 irq drops", {31'b0, irq}, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule